// File: doc/BRIEF.md
# Paged Register Window Decoder

This block sits in front of a control-register space that is larger than the address range a bus slave can see. It takes a plain 32-bit register port of 4 KB. The lower three quarters of that range is decoded directly. The top quarter is a 1 KB window, and software picks which 1 KB page of the internal space the window shows. The choice is made through a 6-bit page field that sits inside a control word, which the block holds itself.

A paged access takes two steps. Software first does a read-modify-write of the control word that changes only the page field. It then reads or writes inside the window. The window offset, with the page number above it, forms a 16-bit internal address. That address is looked up against a small set of implemented register slots. The control word also carries two path-enable bits, and these leave the block as outputs.

Top module: `paged_csr_window`

## Requirements
- R1: After reset, the control word is zero: page 0 and both enables low. Every register slot reads zero, and `rsp_valid` is low.
- R2: The control word lives at byte address 0x808. A write there stores all 32 bits exactly as given, and a read there returns them.
- R3: Control bits 18:13 drive `page_sel`. Bit 0 drives `axi_pio_en` and bit 1 drives `pcie_pio_en`. These outputs change only when the control word is written.
- R4: An access at byte address 0xC00 to 0xFFF reaches internal address (page << 10) | (address & 0x3FC).
- R5: An access below 0xC00, other than 0x808, reaches the internal address equal to the bus address with bits 1:0 cleared.
- R6: Slot k (k = 0..7) sits at internal address k*0x404. A read of any other internal address returns zero, and a write to one changes nothing.
- R7: A new page value applies to the access in the cycle right after the control write.
- R8: Address bits 1:0 play no part in any decode.
- R9: Each read gets `rsp_valid` with its data in the following cycle. A write or an idle cycle gives no response.
- R10: A write to the control word leaves the slot at internal 0x808 unchanged, and a window write to that slot leaves the control word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after the read) |
| rsp_rdata | output | 32 | Read data |
| page_sel | output | 6 | Current page field |
| axi_pio_en | output | 1 | Control bit 0 |
| pcie_pio_en | output | 1 | Control bit 1 |

## Verification
A corrupted page register shows up on `page_sel` at once. It also sends every window access after it to the wrong slot, and that appears as wrong data on the first window read that follows. A slot compare that is wrong appears as a misplaced value or a missing zero in the sweep over all 64 pages. Each page is read one cycle after it is programmed, so a page applied one cycle late fails on that very first read. A control word that aliases with its internal twin at 0x808 fails the cross-checks between the two.

// File: rtl/paged_csr_window.sv
`timescale 1ns/1ps
module paged_csr_window #(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 12,
  parameter int OFS_W       = 10,
  parameter int PAGE_W      = 6,
  parameter int PAGE_LSB    = 13,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 12'h808,
  parameter int NUM_SLOTS   = 8,
  parameter int SLOT_BASE   = 0,
  parameter int SLOT_STRIDE = 'h404
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [PAGE_W-1:0] page_sel,
  output logic              axi_pio_en,
  output logic              pcie_pio_en
);
  localparam int INT_W = PAGE_W + OFS_W;

  logic [DATA_W-1:0] ctl_q;
  logic [ADDR_W-1:0] word;
  logic              in_aper, hit_ctl, rd_req, wr_req;
  logic [INT_W-1:0]  int_addr;
  logic [NUM_SLOTS-1:0] slot_hit;
  logic [DATA_W-1:0] slot_q [NUM_SLOTS];
  logic [DATA_W-1:0] rd_data;

  assign word     = {req_addr[ADDR_W-1:2], 2'b00};
  assign in_aper  = &word[ADDR_W-1:OFS_W];
  assign hit_ctl  = (word == CTL_ADDR);
  assign int_addr = in_aper ? {page_sel, word[OFS_W-1:0]}
                            : {{(INT_W-ADDR_W){1'b0}}, word};
  assign rd_req   = req_valid && !req_write;
  assign wr_req   = req_valid && req_write;

  assign page_sel    = ctl_q[PAGE_LSB +: PAGE_W];
  assign axi_pio_en  = ctl_q[0];
  assign pcie_pio_en = ctl_q[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                ctl_q <= '0;
    else if (wr_req && hit_ctl) ctl_q <= req_wdata;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic [INT_W-1:0] SLOT_A = INT_W'(SLOT_BASE + k * SLOT_STRIDE);
    assign slot_hit[k] = !hit_ctl && (int_addr == SLOT_A);
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                   slot_q[k] <= '0;
      else if (wr_req && slot_hit[k]) slot_q[k] <= req_wdata;
  end

  always_comb begin
    rd_data = hit_ctl ? ctl_q : '0;
    for (int k = 0; k < NUM_SLOTS; k++)
      if (slot_hit[k]) rd_data = rd_data | slot_q[k];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      if (rd_req) rsp_rdata <= rd_data;
    end
endmodule

// File: rtl/paged_csr_window_chk.sv
`timescale 1ns/1ps
module paged_csr_window_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 12,
  parameter int PAGE_W   = 6,
  parameter int PAGE_LSB = 13,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 12'h808
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [PAGE_W-1:0] page_sel,
  input logic              axi_pio_en,
  input logic              pcie_pio_en
);
  logic ctl_wr, rd;
  assign ctl_wr = req_valid && req_write && (req_addr[ADDR_W-1:2] == CTL_ADDR[ADDR_W-1:2]);
  assign rd     = req_valid && !req_write;

  a_r9_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> rsp_valid);
  a_r9_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
  a_r2_ctl_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (page_sel == $past(req_wdata[PAGE_LSB +: PAGE_W])) &&
               (axi_pio_en == $past(req_wdata[0])) &&
               (pcie_pio_en == $past(req_wdata[1])));
  a_r3_ctl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_wr |=> $stable(page_sel) && $stable(axi_pio_en) && $stable(pcie_pio_en));
endmodule

bind paged_csr_window paged_csr_window_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
  .PAGE_LSB(PAGE_LSB), .CTL_ADDR(CTL_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
  .page_sel(page_sel), .axi_pio_en(axi_pio_en), .pcie_pio_en(pcie_pio_en)
);

// File: tb/paged_csr_window_bench.sv
`timescale 1ns/1ps
module paged_csr_window_bench;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, axi_pio_en, pcie_pio_en;
  logic [31:0] rsp_rdata;
  logic [5:0] page_sel;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] mdl [8];
  logic [31:0] ctl_m = '0;

  always #2.5 clk = ~clk;

  paged_csr_window u_paged_csr_window (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .page_sel(page_sel), .axi_pio_en(axi_pio_en),
    .pcie_pio_en(pcie_pio_en));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] to_int(logic [11:0] a);
    logic [11:0] w = {a[11:2], 2'b00};
    if (w >= 12'hC00) return {ctl_m[18:13], w[9:0]};
    return {4'h0, w};
  endfunction

  function automatic int slot_of(logic [15:0] ia);
    if ((ia % 16'h404) == 0 && (ia / 16'h404) < 8) return int'(ia / 16'h404);
    return -1;
  endfunction

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    int s;
    if ({a[11:2], 2'b00} == 12'h808) return ctl_m;
    s = slot_of(to_int(a));
    return (s >= 0) ? mdl[s] : 32'h0;
  endfunction

  task automatic cyc(bit v, bit w, logic [11:0] a, logic [31:0] d);
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    int s;
    cyc(1, 1, a, d);
    if ({a[11:2], 2'b00} == 12'h808) ctl_m = d;
    else begin
      s = slot_of(to_int(a));
      if (s >= 0) mdl[s] = d;
    end
    check("R9", {31'b0, rsp_valid}, 32'h0);
  endtask

  task automatic rd(string tag, logic [11:0] a);
    logic [31:0] e = exp_rd(a);
    cyc(1, 0, a, '0);
    check("R9", {31'b0, rsp_valid}, 32'h1);
    check(tag, rsp_rdata, e);
  endtask

  function automatic logic [31:0] ctl_word(int p);
    logic [31:0] x = 32'(p) * 32'h0105_0321;
    x[18:13] = 6'(p);
    return x;
  endfunction

  function automatic logic [31:0] pat(logic [15:0] ia, logic [31:0] salt);
    return salt ^ (32'(ia) * 32'h0001_0003);
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) mdl[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", {24'b0, page_sel, pcie_pio_en, axi_pio_en}, 32'h0);
    check("R1", {31'b0, rsp_valid}, 32'h0);
    rd("R1", 12'h808);
    rd("R1", 12'hC00);
    rd("R1", 12'h404);

    // R4 window write sweep, all pages (R7: first access follows page write)
    for (int p = 0; p < 64; p++) begin
      wr(12'h808, ctl_word(p));
      for (int w = 0; w < 256; w++)
        wr(12'hC00 | 12'(w * 4), pat({6'(p), 10'(w * 4)}, 32'hA5C3_0000));
    end

    // read sweep
    for (int p = 0; p < 64; p++) begin
      wr(12'h808, ctl_word(p));
      rd("R7", 12'hC00 | 12'((p % 8) * 4 * 257 % 1024));
      check("R3", {24'b0, page_sel, pcie_pio_en, axi_pio_en},
            {24'b0, 6'(p), ctl_word(p)[1:0]});
      rd("R2", 12'h808);
      for (int w = 0; w < 256; w++) begin
        if (slot_of({6'(p), 10'(w * 4)}) >= 0) rd("R4", 12'hC00 | 12'(w * 4));
        else                                 rd("R6", 12'hC00 | 12'(w * 4));
      end
    end

    // R5 direct region
    for (int w = 0; w < 768; w++)
      if (w * 4 != 'h808) wr(12'(w * 4), pat(16'(w * 4), 32'h0F1E_2D3C));
    for (int w = 0; w < 768; w++)
      if (w * 4 != 'h808) rd("R5", 12'(w * 4));

    // R7 back-to-back page change then window access
    for (int p = 0; p < 8; p++) begin
      wr(12'h808, ctl_word(p));
      rd("R7", 12'hC00 | 12'(p * 4));
    end

    // R8 low address bits ignored
    wr(12'h808, ctl_word(3));
    wr(12'hC0F, 32'hDEAD_BEEF);
    rd("R8", 12'hC0D);
    wr(12'h407, 32'h1234_5678);
    rd("R8", 12'h406);
    wr(12'h80B, 32'h0000_4003);
    check("R8", {24'b0, page_sel, pcie_pio_en, axi_pio_en}, {24'b0, 6'd2, 2'b11});
    rd("R8", 12'h80A);

    // R10 control word and internal 0x808 slot are distinct
    wr(12'h808, 32'h0000_4000);
    wr(12'hC08, 32'hCAFE_F00D);
    wr(12'h808, 32'h0000_4001);
    rd("R10", 12'hC08);
    wr(12'hC08, 32'h7777_1111);
    rd("R10", 12'h808);
    rd("R10", 12'hC08);

    // R9 idle gives no response
    cyc(0, 0, 12'h808, '0);
    check("R9", {31'b0, rsp_valid}, 32'h0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule